// File: doc/BRIEF.md
# Program Counter with Return Stack

This block produces the 12-bit instruction fetch address of a small 4-bit controller. It also keeps a four-level return stack for subroutine calls and interrupts. The address has two parts: a page bit in bit 11, and an 11-bit counter in bits 10..0 that steps by one for every executed instruction. Jumps, calls, interrupts and reset load the address instead of stepping it. Each call or interrupt pushes the return address onto the stack together with the current carry flag. A return pops the entry back into the address register. An interrupt return also restores the carry. A return that hands back a table constant leaves the carry alone.

The instruction decoder drives one class strobe per executed instruction and supplies the branch target. When an interrupt is accepted, it also supplies the interrupt source number. The stack is a plain shift structure. If a fifth entry is pushed while four are held, the oldest entry is dropped and nothing is flagged. A pop from an empty stack returns whatever the bottom slot holds.

Top module: `pc_retstack`

## Requirements
- R1: While `rstN` is low, `fetchAddr` is 0x000, `carryOut` is 0 and every stack slot is cleared to zero. Reset overrides every other request.
- R2: When `advance` is the only strobe that wins, bits 10..0 of `fetchAddr` step by one on the next clock and wrap from 0x7FF to 0x000. Bit 11 keeps its value.
- R3: A jump (`doJump`) loads the full 12-bit `targetAddr` into `fetchAddr` on the next clock and leaves the stack untouched.
- R4: A call (`doCall`) loads `targetAddr` and pushes {`carryIn`, return address}. The return address is `fetchAddr` stepped by one under the R2 rule.
- R5: An accepted interrupt (`intReq`) loads vector `intSel`+1: 0 gives 0x001 (external), 1 gives 0x002 (timer 0), 2 gives 0x003 (timer 1) and 3 gives 0x004 (port B). It pushes {`carryIn`, next instruction address}, where the next address is `fetchAddr` stepped under the R2 rule.
- R6: Only one request is served per clock. The order is interrupt, then call, then jump, then return, then advance. With no strobe high, `fetchAddr` and `carryOut` hold.
- R7: A return with `retKeepCarry`=0 (interrupt return) loads `fetchAddr` from the top entry's bits 11..0 and `carryOut` from its bit 12.
- R8: A return with `retKeepCarry`=1 (constant return) loads `fetchAddr` from the top entry and leaves `carryOut` unchanged.
- R9: The stack holds four 13-bit entries and returns them last-in first-out.
- R10: A push while four entries are held discards the oldest entry silently. The four newest entries remain retrievable in LIFO order.
- R11: A pop with no entries held returns the bottom slot's content (zero after reset). The held-entry count never drops below 0 or rises above 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| advance | input | 1 | An ordinary instruction completed; step the counter |
| doJump | input | 1 | Jump or taken branch to `targetAddr` |
| doCall | input | 1 | Subroutine call to `targetAddr` |
| intReq | input | 1 | Interrupt accepted this cycle |
| intSel | input | 2 | Interrupt source, 0..3 |
| targetAddr | input | 12 | Branch or call destination |
| carryIn | input | 1 | Current carry flag, saved on push |
| doReturn | input | 1 | Return instruction, pops the stack |
| retKeepCarry | input | 1 | 1: constant return (carry kept); 0: interrupt return |
| fetchAddr | output | 12 | Current fetch address |
| carryOut | output | 1 | Carry restored by the last interrupt return |

## Verification
The hardest state to reach from the ports is a full stack that has overflowed and then been drained past empty. Only that path exposes the lost oldest entry and the bottom slot repeating its value. Directed sequences make five and more nested calls and interrupts with distinct carries and targets, then more returns than pushes, mixing both return types. Random traffic with a high return rate revisits these states. The bench also forces all strobes high together to test the service order, and places jumps at 0x7FF and 0xFFF to test the page-preserving wrap.

// File: rtl/pcs_pkg.sv
package pcs_pkg;

  // Per-cycle operation selected by the control and applied by the datapath
  typedef struct packed {
    logic incr;         // step the counter
    logic loadTarget;   // take the branch/call target
    logic loadVec;      // take the interrupt vector
    logic push;         // push {carry, return address}
    logic pop;          // pop top entry into the address
    logic restoreCarry; // pop also restores the carry
  } pcOps_t;

endpackage

// File: rtl/pcs_ctrl.sv
module pcs_ctrl
  import pcs_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   advance,
  input  logic   doJump,
  input  logic   doCall,
  input  logic   intReq,
  input  logic   doReturn,
  input  logic   retKeepCarry,
  output pcOps_t ops
);

  localparam int DW = $clog2(DEPTH + 1);
  localparam logic [DW-1:0] FULL = DW'(DEPTH);

  logic [DW-1:0] depthQ;

  // Fixed service order: interrupt, call, jump, return, advance
  always_comb begin
    ops = '0;
    if (intReq) begin
      ops.loadVec = 1'b1;
      ops.push    = 1'b1;
    end else if (doCall) begin
      ops.loadTarget = 1'b1;
      ops.push       = 1'b1;
    end else if (doJump) begin
      ops.loadTarget = 1'b1;
    end else if (doReturn) begin
      ops.pop          = 1'b1;
      ops.restoreCarry = ~retKeepCarry;
    end else if (advance) begin
      ops.incr = 1'b1;
    end
  end

  // Count of held entries, saturating at both ends
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      depthQ <= '0;
    end else if (ops.push) begin
      if (depthQ != FULL) depthQ <= depthQ + 1'b1;
    end else if (ops.pop) begin
      if (depthQ != '0) depthQ <= depthQ - 1'b1;
    end
  end

  // R6
  one_op_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ops.incr, ops.loadTarget, ops.loadVec, ops.pop}));

  // R6
  irq_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    intReq |-> (ops.loadVec && !ops.pop && !ops.incr));

  // R11
  depth_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    depthQ <= FULL);

  // R11
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (depthQ == '0 && ops.pop) |=> depthQ == '0);

  // R10
  full_push_chk: assert property (@(posedge clk) disable iff (!rstN)
    (depthQ == FULL && ops.push) |=> depthQ == FULL);

endmodule

// File: rtl/pcs_datapath.sv
module pcs_datapath
  import pcs_pkg::*;
#(
  parameter int PC_W  = 12,
  parameter int DEPTH = 4,
  parameter int SEL_W = 2
) (
  input  logic            clk,
  input  logic            rstN,
  input  pcOps_t          ops,
  input  logic [PC_W-1:0] targetAddr,
  input  logic [SEL_W-1:0] intSel,
  input  logic            carryIn,
  output logic [PC_W-1:0] pcOut,
  output logic            carryOut
);

  localparam int ENT_W = PC_W + 1;
  localparam int CNT_W = PC_W - 1;

  logic [PC_W-1:0]  pcQ;
  logic             carryQ;
  logic [ENT_W-1:0] stk [DEPTH];
  logic [PC_W-1:0]  pcInc;
  logic [PC_W-1:0]  vecAddr;
  logic [ENT_W-1:0] pushVal;

  // Page bit kept, low counter wraps
  assign pcInc   = {pcQ[PC_W-1], pcQ[CNT_W-1:0] + 1'b1};
  assign vecAddr = PC_W'(intSel) + 1'b1;
  assign pushVal = {carryIn, pcInc};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pcQ <= '0;
    end else if (ops.loadVec) begin
      pcQ <= vecAddr;
    end else if (ops.loadTarget) begin
      pcQ <= targetAddr;
    end else if (ops.pop) begin
      pcQ <= stk[0][PC_W-1:0];
    end else if (ops.incr) begin
      pcQ <= pcInc;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) carryQ <= 1'b0;
    else if (ops.pop && ops.restoreCarry) carryQ <= stk[0][PC_W];
  end

  // Shift-register stack: slot 0 is the top, last slot replicates on pop
  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        stk[i] <= '0;
      end else if (ops.push) begin
        if (i == 0) stk[i] <= pushVal;
        else        stk[i] <= stk[(i == 0) ? 0 : i-1];
      end else if (ops.pop) begin
        if (i == DEPTH-1) stk[i] <= stk[i];
        else              stk[i] <= stk[(i == DEPTH-1) ? i : i+1];
      end
    end
  end

  assign pcOut    = pcQ;
  assign carryOut = carryQ;

  // R2
  step_chk: assert property (@(posedge clk) disable iff (!rstN)
    ops.incr |=> (pcQ[CNT_W-1:0] == $past(pcQ[CNT_W-1:0]) + 1'b1) &&
                 (pcQ[PC_W-1] == $past(pcQ[PC_W-1])));

  // R8
  keep_carry_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ops.pop && !ops.restoreCarry) |=> $stable(carryQ));

  // R4
  push_top_chk: assert property (@(posedge clk) disable iff (!rstN)
    ops.push |=> stk[0] == {$past(carryIn), $past(pcQ[PC_W-1]),
                            $past(pcQ[CNT_W-1:0]) + 1'b1});

  // R9
  pop_return_chk: assert property (@(posedge clk) disable iff (!rstN)
    ops.pop |=> pcQ == $past(stk[0][PC_W-1:0]));

endmodule

// File: rtl/pc_retstack.sv
module pc_retstack
  import pcs_pkg::*;
#(
  parameter int PC_W  = 12,
  parameter int DEPTH = 4,
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             advance,
  input  logic             doJump,
  input  logic             doCall,
  input  logic             intReq,
  input  logic [SEL_W-1:0] intSel,
  input  logic [PC_W-1:0]  targetAddr,
  input  logic             carryIn,
  input  logic             doReturn,
  input  logic             retKeepCarry,
  output logic [PC_W-1:0]  fetchAddr,
  output logic             carryOut
);

  pcOps_t ops;

  pcs_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .advance      (advance),
    .doJump       (doJump),
    .doCall       (doCall),
    .intReq       (intReq),
    .doReturn     (doReturn),
    .retKeepCarry (retKeepCarry),
    .ops          (ops)
  );

  pcs_datapath #(.PC_W(PC_W), .DEPTH(DEPTH), .SEL_W(SEL_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .ops        (ops),
    .targetAddr (targetAddr),
    .intSel     (intSel),
    .carryIn    (carryIn),
    .pcOut      (fetchAddr),
    .carryOut   (carryOut)
  );

  // R5
  vector_chk: assert property (@(posedge clk) disable iff (!rstN)
    intReq |=> fetchAddr == PC_W'($past(intSel)) + 1'b1);

  // R3
  jump_chk: assert property (@(posedge clk) disable iff (!rstN)
    (doJump && !doCall && !intReq) |=> fetchAddr == $past(targetAddr));

  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(advance || doJump || doCall || intReq || doReturn)
      |=> ($stable(fetchAddr) && $stable(carryOut)));

endmodule

// File: tb/pc_retstack_test.sv
`timescale 1ns/1ps
module pc_retstack_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        advance = 0, doJump = 0, doCall = 0, intReq = 0;
  logic [1:0]  intSel = 0;
  logic [11:0] targetAddr = 0;
  logic        carryIn = 0, doReturn = 0, retKeepCarry = 0;
  logic [11:0] fetchAddr;
  logic        carryOut;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pc_retstack uut (
    .clk(clk), .rstN(rstN), .advance(advance), .doJump(doJump),
    .doCall(doCall), .intReq(intReq), .intSel(intSel),
    .targetAddr(targetAddr), .carryIn(carryIn), .doReturn(doReturn),
    .retKeepCarry(retKeepCarry), .fetchAddr(fetchAddr), .carryOut(carryOut)
  );

  // Behavioural reference model
  logic [11:0] mPc;
  logic        mCy;
  logic [12:0] q[$];
  logic [12:0] floorVal;
  string       tag = "R1";

  function automatic logic [11:0] stepOf(logic [11:0] a);
    return {a[11], 11'(a[10:0] + 11'd1)};
  endfunction

  task automatic modelPush(logic [12:0] v);
    q.push_front(v);
    if (q.size() > 4) begin
      void'(q.pop_back());
      tag = "R10";
    end
  endtask

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mPc = 0; mCy = 0; q.delete(); floorVal = 0; tag = "R1";
    end else if (intReq) begin
      modelPush({carryIn, stepOf(mPc)});
      if (tag != "R10") tag = "R5";
      mPc = 12'(intSel) + 12'd1;
    end else if (doCall) begin
      modelPush({carryIn, stepOf(mPc)});
      if (tag != "R10") tag = "R4";
      mPc = targetAddr;
    end else if (doJump) begin
      mPc = targetAddr; tag = "R3";
    end else if (doReturn) begin
      logic [12:0] v;
      if (q.size() == 0) begin
        v = floorVal; tag = "R11";
      end else begin
        if (q.size() == 4) floorVal = q[3];
        v = q.pop_front();
        tag = retKeepCarry ? "R8" : "R7";
      end
      mPc = v[11:0];
      if (!retKeepCarry) mCy = v[12];
    end else if (advance) begin
      mPc = stepOf(mPc); tag = "R2";
    end else begin
      tag = "R6";
    end
  end

  // Compare on every falling edge, away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      cycles++;
      checks++;
      if (fetchAddr !== mPc || carryOut !== mCy) begin
        errors++;
        $display("FAIL %s: cycle %0d actual addr=%h cy=%b expected addr=%h cy=%b",
                 tag, cycles, fetchAddr, carryOut, mPc, mCy);
      end
    end
  end

  task automatic finishRun();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(5.0 * 100000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finishRun();
  end

  task automatic idle();
    advance = 0; doJump = 0; doCall = 0; intReq = 0; doReturn = 0;
  endtask

  task automatic cyc(input logic a, j, c, i, input logic [1:0] s,
                     input logic [11:0] t, input logic ci, r, k);
    @(negedge clk);
    #0.5;
    advance = a; doJump = j; doCall = c; intReq = i; intSel = s;
    targetAddr = t; carryIn = ci; doReturn = r; retKeepCarry = k;
  endtask

  initial begin
    // R1: outputs during and after reset
    repeat (3) @(negedge clk);
    checks++;
    if (fetchAddr !== 12'h000 || carryOut !== 1'b0) begin
      errors++;
      $display("FAIL R1: actual addr=%h cy=%b expected addr=000 cy=0", fetchAddr, carryOut);
    end
    #0.5 rstN = 1;
    // R11: empty pop right after reset returns zero
    cyc(0,0,0,0,0,12'h000,1,1,0);
    cyc(0,0,0,0,0,12'h000,1,1,1);
    // R2: wrap keeps page bit
    cyc(0,1,0,0,0,12'h7FE,0,0,0);
    repeat (3) cyc(1,0,0,0,0,12'h000,0,0,0);
    cyc(0,1,0,0,0,12'hFFE,0,0,0);
    repeat (3) cyc(1,0,0,0,0,12'h000,0,0,0);
    // R4 R5 R10: six nested pushes, distinct carries
    cyc(0,0,1,0,0,12'h111,1,0,0);
    cyc(0,0,0,1,2'd0,12'h000,0,0,0);
    cyc(0,0,1,0,0,12'h9A5,1,0,0);
    cyc(0,0,0,1,2'd3,12'h000,1,0,0);
    cyc(0,0,1,0,0,12'h5C3,0,0,0);
    cyc(0,0,0,1,2'd2,12'h000,1,0,0);
    // R7 R8 R9 R11: drain past empty, mixing return kinds
    for (int n = 0; n < 7; n++) cyc(0,0,0,0,0,12'h000,0,1,n[0]);
    // R6: all strobes together, then each lower pair
    cyc(1,1,1,1,2'd1,12'h3AB,1,1,0);
    cyc(1,1,1,0,2'd1,12'h3AB,0,1,0);
    cyc(1,1,0,0,2'd1,12'h456,0,1,0);
    cyc(1,0,0,0,2'd1,12'h456,0,1,1);
    cyc(0,0,0,0,2'd1,12'h456,0,0,0);
    cyc(0,0,0,0,2'd1,12'h456,0,0,0);
    // Random traffic with a mid-run reset
    for (int n = 0; n < 4000; n++) begin
      int r = $urandom_range(0, 99);
      if (n == 2000) begin
        @(negedge clk); #0.5 rstN = 0; idle();
        @(negedge clk); #0.5 rstN = 1;
      end
      cyc(r < 40, (r >= 40 && r < 50) || r == 99, (r >= 50 && r < 62),
          (r >= 62 && r < 70) || r == 98, 2'($urandom),
          12'($urandom), 1'($urandom), (r >= 70 && r < 90) || r > 95,
          1'($urandom));
    end
    cyc(0,0,0,0,0,12'h000,0,0,0);
    repeat (2) @(negedge clk);
    finishRun();
  end

endmodule